// File: doc/BRIEF.md
# Up/Down Timer-Counter with Compare Unit

This block is an 8-bit timer-counter that steps once for each enabled tick. The tick comes from a prescaler or from an external event source elsewhere in the chip. A direction input chooses whether the counter counts up or down. A synchronous clear input forces the count to zero. The counter is compared with an active compare value on every cycle. A match on a counting tick produces a one-cycle event pulse for a downstream waveform generator and sets a sticky compare flag that can drive an interrupt.

The counter's upper limit (TOP) is selected by a mode register. TOP is either the full-scale value or the active compare value. In buffered mode, software writes to the compare register go to a holding buffer. That buffer is copied into the active compare value only at a wrap, so a period change never cuts a cycle short. Software also has write access to the counter, the compare register, the mode and the flag-clear bits through a small register interface. A sticky overflow flag records every wrap.

Top module: `updown_timer`

## Requirements
- R1: After reset (rst_n low at a clock edge) the counter, the active compare value, the compare buffer and both flags are zero, `cmp_event` is low, and the mode is full-scale TOP, unbuffered.
- R2: On a cycle with `tick` high and no clear or counter write, the counter goes up by one if `count_down` is 0 and down by one if it is 1. With `tick` low, the counter holds its value.
- R3: `sync_clr` high sets the counter to zero at the next edge. It overrides a tick and a counter write in the same cycle.
- R4: `at_bottom` is high exactly when the counter is 0x00. `at_top` is high exactly when the counter equals TOP. TOP is 0xFF when mode bit 0 is 0, and the active compare value when mode bit 0 is 1.
- R5: An up-tick with the counter at TOP or at 0xFF makes the counter 0x00. A down-tick with the counter at 0x00 loads TOP. This step is called a wrap.
- R6: A wrap sets `ovf_flag`, which stays set until software clears it.
- R7: A counting tick on which the counter equals the active compare value raises `cmp_event` for exactly the following cycle and sets `cmp_flag` at the same edge.
- R8: Register writes use `reg_addr` values 0 = counter, 1 = compare, 2 = mode and 3 = flag clear. Mode bit 0 selects compare-as-TOP and mode bit 1 selects buffered compare. In unbuffered mode, a compare write sets the active compare value at the next edge. In buffered mode, the write goes only to the buffer, and the active compare value is loaded from the buffer at the next wrap.
- R9: A write to address 3 clears `ovf_flag` if data bit 0 is 1 and clears `cmp_flag` if data bit 1 is 1. If a set event falls in the same cycle as the clear, the flag stays set.
- R10: After a counter write, the next counting tick produces no compare match, even when the written value equals the active compare value.
- R11: A write to address 0 loads `reg_wdata` into the counter at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable (prescaled or external tick) |
| count_down | input | 1 | 1 = decrement, 0 = increment |
| sync_clr | input | 1 | Synchronous counter clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 counter, 1 compare, 2 mode, 3 flag clear) |
| reg_wdata | input | 8 | Register write data |
| cnt_value | output | 8 | Current counter value |
| cmp_value | output | 8 | Active compare value |
| at_top | output | 1 | Counter equals TOP |
| at_bottom | output | 1 | Counter equals zero |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| cmp_event | output | 1 | One-cycle compare-match pulse |

## Verification
A wrong count or a wrong wrap target shows on `cnt_value` one cycle after the faulty tick, and it also shifts every later `at_top` and `at_bottom` reading. A compare buffer that loads too early, or a missing match suppression, shows as an early or spurious `cmp_event` on the very next counting tick. A wrong buffered value shows on `cmp_value` right after the next wrap. A flag-priority error shows as a flag reading 0 in the cycle after a simultaneous set and clear.

// File: rtl/tmr_pkg.sv
// Package: shared register-select encoding and mode layout for the timer.
// Assumes a 2-bit register address on the write interface.
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_FLAGS = 2'd3
    } reg_sel_e;

    // Mode register contents; bit 0 = compare as TOP, bit 1 = buffered compare.
    typedef struct packed {
        logic buffered;
        logic top_is_cmp;
    } mode_t;

    localparam int FLAG_OVF_BIT = 0;
    localparam int FLAG_CMP_BIT = 1;

endpackage

// File: rtl/tmr_regs.sv
// Register block: decodes software writes, holds the mode, the compare
// buffer and the active compare value. It loads the buffer into the active
// value on a wrap when buffered mode is on.
// Assumes wrap_evt is a single-cycle strobe from the counter unit.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         wrap_evt,
    output mode_t        mode,
    output logic [W-1:0] cmp_live,
    output logic         cnt_ld,
    output logic [W-1:0] cnt_ld_val,
    output logic         clr_ovf,
    output logic         clr_cmp
);

    reg_sel_e     sel;
    logic         wr_cmp;
    logic         wr_mode;
    logic [W-1:0] cmp_buf;

    // Decode the write strobe into per-register actions.
    always_comb begin
        sel        = reg_sel_e'(wr_addr);
        cnt_ld     = wr_en && (sel == SEL_COUNT);
        wr_cmp     = wr_en && (sel == SEL_CMP);
        wr_mode    = wr_en && (sel == SEL_MODE);
        clr_ovf    = wr_en && (sel == SEL_FLAGS) && wr_data[FLAG_OVF_BIT];
        clr_cmp    = wr_en && (sel == SEL_FLAGS) && wr_data[FLAG_CMP_BIT];
        cnt_ld_val = wr_data;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (wr_mode) mode <= mode_t'(wr_data[1:0]);
    end

    // Compare buffer: always takes the software value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_buf <= '0;
        else if (wr_cmp) cmp_buf <= wr_data;
    end

    // Active compare value: direct write when unbuffered, wrap load when buffered.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmp_live <= '0;
        else if (!mode.buffered && wr_cmp)   cmp_live <= wr_data;
        else if (mode.buffered && wrap_evt)  cmp_live <= cmp_buf;
    end

    // R8: an unbuffered compare write is visible at the next edge.
    p_unbuf_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !mode.buffered) |=> (cmp_live == $past(wr_data)));

    // R8: in buffered mode the active value changes only on a wrap.
    p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.buffered && !wrap_evt && !wr_mode) |=> $stable(cmp_live));

endmodule

// File: rtl/tmr_counter.sv
// Counter unit: up/down counter with clear, software load and TOP-based wrap.
// It drives the TOP and BOTTOM indicators and a wrap strobe.
// Assumes top_val is stable within a cycle; full scale is all ones.
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         down,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output logic         wrap_evt,
    output logic         at_top,
    output logic         at_bot
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic step;
    logic wrap_up;
    logic wrap_dn;

    // Work out whether this cycle steps and whether the step wraps.
    always_comb begin
        step     = tick && !clr && !ld;
        wrap_up  = (cnt == top_val) || (cnt == MAXV);
        wrap_dn  = (cnt == '0);
        wrap_evt = step && (down ? wrap_dn : wrap_up);
        at_top   = (cnt == top_val);
        at_bot   = wrap_dn;
    end

    // Counter register: clear > load > step.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (ld)    cnt <= ld_val;
        else if (step) begin
            if (down)   cnt <= wrap_dn ? top_val : cnt - ONE;
            else        cnt <= wrap_up ? '0 : cnt + ONE;
        end
    end

    // R3: clear always yields zero.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R2: a non-wrapping up-step adds one.
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !down && !wrap_up) |=> (cnt == $past(cnt) + ONE));

    // R2: no tick, no clear, no load -> hold.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr && !ld) |=> $stable(cnt));

    // R5: a down-wrap lands on the TOP in force at that tick.
    p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down && at_bot) |=> (cnt == $past(top_val)));

    // R11: a load without clear takes the written value.
    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (cnt == $past(ld_val)));

endmodule

// File: rtl/tmr_compare.sv
// Compare unit: detects a match between the counter and the active compare
// value on a counting tick, holds off one tick after a counter write, and
// registers a one-cycle event pulse.
// Assumes ld and clr come from the same cycle as tick.
module tmr_compare #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_live,
    output logic         hit,
    output logic         evt
);

    logic hold_off;

    // Match qualified by a counting tick and the post-write hold-off.
    always_comb begin
        hit = tick && !clr && !ld && !hold_off && (cnt == cmp_live);
    end

    // Hold-off: armed by a counter write, released by the next counting tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_off <= 1'b0;
        else if (ld)                    hold_off <= 1'b1;
        else if (tick && !clr)          hold_off <= 1'b0;
    end

    // Event pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= hit;
    end

    // R10: no match can be taken in the cycle after a counter write.
    p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !hit);

    // R7: every match yields the event pulse one cycle later.
    p_evt_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> evt);

    // R7: the event is never raised without a preceding match.
    p_evt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !evt);

endmodule

// File: rtl/tmr_flags.sv
// Sticky flag pair: overflow and compare match. Set by hardware events,
// cleared by write-one from software; a set in the same cycle wins.
// Assumes set and clear inputs are single-cycle qualified strobes.
module tmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic cmp_set,
    input  logic ovf_clr,
    input  logic cmp_clr,
    output logic ovf_q,
    output logic cmp_q
);

    // Update both flags with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            cmp_q <= 1'b0;
        end else begin
            ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
            cmp_q <= cmp_set | (cmp_q & ~cmp_clr);
        end
    end

    // R6 and R9: an overflow set is visible next cycle even under a clear.
    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_q);

    // R9: a compare-flag set wins over a simultaneous clear.
    p_cmp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_set |=> cmp_q);

    // R9: a clear with no set drops the flag.
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !ovf_set) |=> !ovf_q);

endmodule

// File: rtl/updown_timer.sv
// Top: up/down timer-counter with double-buffered compare unit.
// Ties the register block, counter, compare and flag units together and
// selects TOP from the mode. Assumes tick is already synchronous to clk.
module updown_timer
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         count_down,
    input  logic         sync_clr,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] cnt_value,
    output logic [W-1:0] cmp_value,
    output logic         at_top,
    output logic         at_bottom,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic         cmp_event
);

    localparam logic [W-1:0] FULL = '1;

    mode_t        mode;
    logic [W-1:0] cmp_live;
    logic [W-1:0] top_val;
    logic         cnt_ld;
    logic [W-1:0] cnt_ld_val;
    logic         clr_ovf;
    logic         clr_cmp;
    logic         wrap_evt;
    logic         hit;

    // TOP select: full scale or the active compare value.
    always_comb begin
        top_val = mode.top_is_cmp ? cmp_live : FULL;
    end

    tmr_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .wrap_evt   (wrap_evt),
        .mode       (mode),
        .cmp_live   (cmp_live),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .clr_ovf    (clr_ovf),
        .clr_cmp    (clr_cmp)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .down     (count_down),
        .clr      (sync_clr),
        .ld       (cnt_ld),
        .ld_val   (cnt_ld_val),
        .top_val  (top_val),
        .cnt      (cnt_value),
        .wrap_evt (wrap_evt),
        .at_top   (at_top),
        .at_bot   (at_bottom)
    );

    tmr_compare #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (sync_clr),
        .ld       (cnt_ld),
        .cnt      (cnt_value),
        .cmp_live (cmp_live),
        .hit      (hit),
        .evt      (cmp_event)
    );

    tmr_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_set (wrap_evt),
        .cmp_set (hit),
        .ovf_clr (clr_ovf),
        .cmp_clr (clr_cmp),
        .ovf_q   (ovf_flag),
        .cmp_q   (cmp_flag)
    );

    assign cmp_value = cmp_live;

    // R4: the two boundary indicators agree with the count.
    p_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        at_bottom == (cnt_value == '0));

    // R1: the cycle after reset is fully idle.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_value == '0 && !ovf_flag && !cmp_flag && !cmp_event));

endmodule

// File: tb/updown_timer_test.sv
// Bench for updown_timer: table of vectors walked by one loop, then directed
// checks for reset, buffering and mode corners.
module updown_timer_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick, count_down, sync_clr, reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] cnt_value, cmp_value;
    logic       at_top, at_bottom, ovf_flag, cmp_flag, cmp_event;

    int applied = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    updown_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_down(count_down),
        .sync_clr(sync_clr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cnt_value(cnt_value), .cmp_value(cmp_value),
        .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .cmp_event(cmp_event)
    );

    typedef struct packed {
        logic       tk; logic dn; logic cl; logic wr;
        logic [1:0] ad; logic [7:0] dt;
        logic [7:0] e_cnt; logic e_evt; logic e_ovf; logic e_cf;
        logic e_top; logic e_bot;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VEC [NV] = '{
        '{0,0,0,1,2'd1,8'h03, 8'h00,0,0,0,0,1}, // 1  R8 unbuffered compare=3
        '{1,0,0,0,2'd0,8'h00, 8'h01,0,0,0,0,0}, // 2  R2 up
        '{1,0,0,0,2'd0,8'h00, 8'h02,0,0,0,0,0}, // 3
        '{1,0,0,0,2'd0,8'h00, 8'h03,0,0,0,0,0}, // 4
        '{1,0,0,0,2'd0,8'h00, 8'h04,1,0,1,0,0}, // 5  R7 match at 3
        '{0,0,0,0,2'd0,8'h00, 8'h04,0,0,1,0,0}, // 6  R2 hold, R7 pulse ends
        '{0,0,0,1,2'd3,8'h02, 8'h04,0,0,0,0,0}, // 7  R9 clear cmp flag
        '{1,1,0,0,2'd0,8'h00, 8'h03,0,0,0,0,0}, // 8  R2 down
        '{1,1,0,0,2'd0,8'h00, 8'h02,1,0,1,0,0}, // 9  R7 match counting down
        '{0,0,0,1,2'd3,8'h02, 8'h02,0,0,0,0,0}, // 10 R9
        '{0,0,0,1,2'd0,8'h03, 8'h03,0,0,0,0,0}, // 11 R11 counter write
        '{1,0,0,0,2'd0,8'h00, 8'h04,0,0,0,0,0}, // 12 R10 match suppressed
        '{1,1,0,0,2'd0,8'h00, 8'h03,0,0,0,0,0}, // 13
        '{1,1,0,0,2'd0,8'h00, 8'h02,1,0,1,0,0}, // 14 R10 suppression released
        '{0,0,0,1,2'd0,8'hFE, 8'hFE,0,0,1,0,0}, // 15 R11
        '{1,0,0,0,2'd0,8'h00, 8'hFF,0,0,1,1,0}, // 16 R4 at_top at 0xFF
        '{1,0,0,0,2'd0,8'h00, 8'h00,0,1,1,0,1}, // 17 R5 R6 up wrap
        '{1,0,1,0,2'd0,8'h00, 8'h00,0,1,1,0,1}, // 18 R3 clear beats tick
        '{0,0,0,1,2'd3,8'h01, 8'h00,0,0,1,0,1}, // 19 R9 clear ovf
        '{1,1,0,0,2'd0,8'h00, 8'hFF,0,1,1,1,0}, // 20 R5 down wrap to TOP
        '{1,1,0,1,2'd3,8'h03, 8'hFE,0,0,0,0,0}, // 21 R9 clear both while ticking
        '{0,0,0,1,2'd2,8'h01, 8'hFE,0,0,0,0,0}, // 22 R8 mode: TOP = compare
        '{0,0,0,1,2'd0,8'h02, 8'h02,0,0,0,0,0}, // 23 R11
        '{1,0,0,0,2'd0,8'h00, 8'h03,0,0,0,1,0}, // 24 R4 at_top = compare
        '{1,0,0,0,2'd0,8'h00, 8'h00,1,1,1,0,1}, // 25 R5 R7 wrap at compare TOP
        '{0,0,0,1,2'd3,8'h03, 8'h00,0,0,0,0,1}, // 26 R9
        '{0,0,0,1,2'd2,8'h03, 8'h00,0,0,0,0,1}, // 27 R8 buffered
        '{0,0,0,1,2'd1,8'h05, 8'h00,0,0,0,0,1}, // 28 R8 to buffer only
        '{1,0,0,0,2'd0,8'h00, 8'h01,0,0,0,0,0}, // 29
        '{1,0,0,0,2'd0,8'h00, 8'h02,0,0,0,0,0}, // 30
        '{1,0,0,0,2'd0,8'h00, 8'h03,0,0,0,1,0}, // 31 R8 old TOP still active
        '{1,0,0,0,2'd0,8'h00, 8'h00,1,1,1,0,1}, // 32 R8 wrap loads buffer
        '{1,0,0,0,2'd0,8'h00, 8'h01,0,1,1,0,0}, // 33
        '{1,0,0,0,2'd0,8'h00, 8'h02,0,1,1,0,0}, // 34
        '{1,0,0,0,2'd0,8'h00, 8'h03,0,1,1,0,0}, // 35 R8 3 no longer TOP
        '{1,0,0,0,2'd0,8'h00, 8'h04,0,1,1,0,0}, // 36
        '{1,0,0,0,2'd0,8'h00, 8'h05,0,1,1,1,0}, // 37
        '{1,0,0,0,2'd0,8'h00, 8'h00,1,1,1,0,1}, // 38 R5 wrap at new TOP
        '{0,0,0,1,2'd3,8'h03, 8'h00,0,0,0,0,1}, // 39 R9
        '{1,1,0,1,2'd3,8'h01, 8'h05,0,1,0,1,0}  // 40 R9 set wins over clear
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; sample 5 ns after the rising edge.
    task automatic cyc(input logic tk, input logic dn, input logic cl,
                       input logic wr, input logic [1:0] ad, input logic [7:0] dt);
        @(negedge clk);
        tick = tk; count_down = dn; sync_clr = cl;
        reg_wr = wr; reg_addr = ad; reg_wdata = dt;
        @(posedge clk);
        #5;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tick = 0; count_down = 0; sync_clr = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        cyc(0, 0, 0, 0, 2'd0, 8'h00);
        cyc(0, 0, 0, 0, 2'd0, 8'h00);
        // R1 reset state
        check("R1 cnt", cnt_value, 8'h00);
        check("R1 cmp", cmp_value, 8'h00);
        check("R1 flags/evt", {5'd0, ovf_flag, cmp_flag, cmp_event}, 8'h00);
        check("R4 reset boundary", {6'd0, at_top, at_bottom}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].tk, VEC[i].dn, VEC[i].cl, VEC[i].wr, VEC[i].ad, VEC[i].dt);
            check($sformatf("R2/R3/R5/R11 count v%0d", i + 1), cnt_value, VEC[i].e_cnt);
            check($sformatf("R7/R10 event v%0d", i + 1), {7'd0, cmp_event}, {7'd0, VEC[i].e_evt});
            check($sformatf("R6/R9 ovf v%0d", i + 1), {7'd0, ovf_flag}, {7'd0, VEC[i].e_ovf});
            check($sformatf("R7/R9 cmpflag v%0d", i + 1), {7'd0, cmp_flag}, {7'd0, VEC[i].e_cf});
            check($sformatf("R4 top/bot v%0d", i + 1), {6'd0, at_top, at_bottom},
                  {6'd0, VEC[i].e_top, VEC[i].e_bot});
        end

        // R8: buffered load at the wrap took the value 5
        check("R8 active after wrap", cmp_value, 8'h05);
        // R8: buffered write does not reach the active value
        cyc(0, 0, 0, 1, 2'd1, 8'h09);
        check("R8 buffered hold", cmp_value, 8'h05);
        // R8: unbuffered write reaches it at once
        cyc(0, 0, 0, 1, 2'd2, 8'h00);
        cyc(0, 0, 0, 1, 2'd1, 8'h07);
        check("R8 unbuffered immediate", cmp_value, 8'h07);
        // R3: clear beats a counter write in the same cycle
        cyc(0, 0, 1, 1, 2'd0, 8'h44);
        check("R3 clear over write", cnt_value, 8'h00);
        // R5: up at 0xFF wraps even when TOP (compare) is lower
        cyc(0, 0, 0, 1, 2'd2, 8'h01);
        cyc(0, 0, 0, 1, 2'd0, 8'hFF);
        cyc(1, 0, 0, 0, 2'd0, 8'h00);
        check("R5 full-scale wrap", cnt_value, 8'h00);
        check("R6 ovf on full-scale wrap", {7'd0, ovf_flag}, 8'h01);
        // R1: reset in mid-run returns everything to idle
        @(negedge clk);
        rst_n = 1'b0;
        cyc(1, 0, 0, 0, 2'd0, 8'h00);
        check("R1 mid-run cnt", cnt_value, 8'h00);
        check("R1 mid-run cmp", cmp_value, 8'h00);
        check("R1 mid-run flags", {6'd0, ovf_flag, cmp_flag}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule